// File: doc/BRIEF.md
# Multichannel Grayscale PWM Generator

The block drives a bank of on/off channel enables from one shared grayscale counter. Each channel compares its own grayscale value against the count and is on while the count is lower than that value. The counter advances on the rising edges of a reference clock. Two reference clocks are offered, one internal and one external, and a control bit picks between them. Both reference inputs are sampled into the block's system clock domain, and edges are found there.

Grayscale values and four control bits (blank, restart enable, clock select, output edge) are presented in parallel. They are captured only when a one-cycle load pulse arrives, so a running count never sees a value change part way through. A load can restart the PWM cycle. It does so when its restart-enable bit is set, and also whenever it toggles the blank bit. A restart clears the counter and switches every channel off. Counting then resumes from zero at the next rising reference edge.

When the output-edge bit selects the falling edge, each channel's on/off decision is still formed at the rising edge, but it reaches the output at the following falling edge. Devices set to opposite edges therefore switch half a reference period apart.

Top module: `gs_pwm_bank`

## Requirements
- R1: Twelve channels each hold a 16-bit grayscale value. The value on `gs_i` is stored only when `load_i` is high; changes to `gs_i` between load pulses have no effect on the outputs.
- R2: After the count c has been taken at a rising reference edge, channel i is on exactly when c < value_i. A value of 0 keeps the channel off.
- R3: Each rising edge of the selected reference advances the counter by one, and 65535 wraps to 0. A value of 65535 is therefore off for one count in every 65536.
- R4: With `cfg_ext_sel_i` latched as 0, only `ref_int_i` advances the count. With it latched as 1, only `ref_ext_i` does.
- R5: A load with `cfg_restart_en_i` = 1 clears the counter and drives all of `pwm_o` to 0 in the cycle after the load. The first rising reference edge after that uses count 0.
- R6: A load with `cfg_restart_en_i` = 0 and an unchanged blank bit neither clears the counter nor forces any output off.
- R7: A load that changes the blank bit, whether 0 to 1 or 1 to 0, restarts exactly as in R5, even when the restart enable is 0.
- R8: While the latched blank bit is 1, all outputs stay off and the counter stays at 0, whatever the reference inputs do.
- R9: With `cfg_rise_i` latched as 1, outputs change only after a rising edge of the selected reference. With it latched as 0, the decision made at a rising edge appears only after the next falling edge.
- R10: The control inputs act only through a load pulse; changing them without `load_i` alters nothing.
- R11: After reset, all outputs are off, blank is latched as 1 and all grayscale values are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_int_i | input | 1 | Internal grayscale reference clock, sampled |
| ref_ext_i | input | 1 | External grayscale reference clock, sampled |
| load_i | input | 1 | One-cycle pulse that captures values and control bits |
| cfg_blank_i | input | 1 | Blank bit: 1 holds all channels off |
| cfg_restart_en_i | input | 1 | Restart enable: 1 makes a load restart the cycle |
| cfg_ext_sel_i | input | 1 | Reference select: 0 internal, 1 external |
| cfg_rise_i | input | 1 | Output edge: 1 rising, 0 falling |
| gs_i | input | 192 | Grayscale values; channel i in bits [16i+15:16i] |
| pwm_o | output | 12 | Registered channel enables, bit i is channel i |

## Verification
The wrap from 65535 to 0 is the hardest state to reach from the ports. It needs 65536 reference edges after a restart. The bench reaches it by toggling the internal reference on every system clock for 65535 edges, then stepping single slow edges to watch a full-scale channel switch off for exactly one count and both channels come back on at count 0. Falling-edge mode is also awkward to observe, because the decision and the visible change sit half a reference period apart. Every slow edge is therefore checked twice: once after its high phase and once after its low phase.

// File: rtl/gs_pwm_pkg.sv
package gs_pwm_pkg;
  typedef struct packed {
    logic blank;
    logic restart_en;
    logic ext_sel;
    logic rise_mode;
  } gs_ctl_t;
endpackage

// File: rtl/gs_ref_edge.sv
module gs_ref_edge #(
  parameter int SYNC = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic ref_int_i,
  input  logic ref_ext_i,
  input  logic ext_sel_i,
  output logic rise_o,
  output logic fall_o
);
  logic [SYNC-1:0] int_sync, ext_sync;
  logic sel_now, sel_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      int_sync <= '0;
      ext_sync <= '0;
    end else begin
      int_sync[0] <= ref_int_i;
      ext_sync[0] <= ref_ext_i;
      for (int k = 1; k < SYNC; k++) begin
        int_sync[k] <= int_sync[k-1];
        ext_sync[k] <= ext_sync[k-1];
      end
    end
  end

  assign sel_now = ext_sel_i ? ext_sync[SYNC-1] : int_sync[SYNC-1];

  always_ff @(posedge clk) begin
    if (rst) sel_prev <= 1'b0;
    else     sel_prev <= sel_now;
  end

  assign rise_o = sel_now & ~sel_prev;
  assign fall_o = ~sel_now & sel_prev;
endmodule

// File: rtl/gs_cfg_latch.sv
module gs_cfg_latch
  import gs_pwm_pkg::*;
#(
  parameter int CH = 12,
  parameter int W  = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_i,
  input  gs_ctl_t       ctl_i,
  input  logic [CH*W-1:0] gs_i,
  output gs_ctl_t       ctl_o,
  output logic [CH*W-1:0] gs_o,
  output logic          restart_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_o <= '{blank: 1'b1, restart_en: 1'b0, ext_sel: 1'b0, rise_mode: 1'b0};
      gs_o  <= '0;
    end else if (load_i) begin
      ctl_o <= ctl_i;
      gs_o  <= gs_i;
    end
  end

  assign restart_o = load_i & (ctl_i.restart_en | (ctl_i.blank ^ ctl_o.blank));

  // R1
  gs_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !load_i |=> $stable(gs_o));
  // R10
  ctl_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !load_i |=> $stable(ctl_o));
endmodule

// File: rtl/gs_counter.sv
module gs_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         rise_i,
  input  logic         restart_i,
  input  logic         blank_i,
  output logic [W-1:0] cnt_o
);
  always_ff @(posedge clk) begin
    if (rst || restart_i || blank_i) cnt_o <= '0;
    else if (rise_i)                 cnt_o <= cnt_o + 1'b1;
  end

  // R3
  cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
    rise_i && !restart_i && !blank_i |=> cnt_o == W'($past(cnt_o) + 1'b1));
  // R3
  cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rise_i && !restart_i |=> $stable(cnt_o));
  // R5
  cnt_clear_chk: assert property (@(posedge clk) disable iff (rst)
    restart_i |=> cnt_o == '0);
endmodule

// File: rtl/gs_chan_out.sv
module gs_chan_out #(
  parameter int CH = 12,
  parameter int W  = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [W-1:0]    cnt_i,
  input  logic [CH*W-1:0] gs_i,
  input  logic            rise_i,
  input  logic            fall_i,
  input  logic            rise_mode_i,
  input  logic            blank_i,
  input  logic            restart_i,
  output logic [CH-1:0]   pwm_o
);
  logic [CH-1:0] cmp, cmp_q;

  for (genvar i = 0; i < CH; i++) begin : g_cmp
    assign cmp[i] = cnt_i < gs_i[i*W +: W];
  end

  always_ff @(posedge clk) begin
    if (rst || restart_i || blank_i) begin
      cmp_q <= '0;
      pwm_o <= '0;
    end else begin
      if (rise_i) cmp_q <= cmp;
      if (rise_mode_i && rise_i)       pwm_o <= cmp;
      else if (!rise_mode_i && fall_i) pwm_o <= cmp_q;
    end
  end

  // R5
  forced_off_chk: assert property (@(posedge clk) disable iff (rst)
    restart_i |=> pwm_o == '0);
  // R8
  blank_off_chk: assert property (@(posedge clk) disable iff (rst)
    blank_i |=> pwm_o == '0);
  // R9
  pwm_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(rise_mode_i ? rise_i : fall_i) && !restart_i && !blank_i |=> $stable(pwm_o));
endmodule

// File: rtl/gs_pwm_bank.sv
module gs_pwm_bank
  import gs_pwm_pkg::*;
#(
  parameter int CH   = 12,
  parameter int W    = 16,
  parameter int SYNC = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ref_int_i,
  input  logic            ref_ext_i,
  input  logic            load_i,
  input  logic            cfg_blank_i,
  input  logic            cfg_restart_en_i,
  input  logic            cfg_ext_sel_i,
  input  logic            cfg_rise_i,
  input  logic [CH*W-1:0] gs_i,
  output logic [CH-1:0]   pwm_o
);
  gs_ctl_t         ctl_in, ctl_q;
  logic [CH*W-1:0] gs_q;
  logic            restart, rise, fall;
  logic [W-1:0]    cnt;

  assign ctl_in = '{blank: cfg_blank_i, restart_en: cfg_restart_en_i,
                    ext_sel: cfg_ext_sel_i, rise_mode: cfg_rise_i};

  gs_cfg_latch #(.CH(CH), .W(W)) u_cfg (
    .clk(clk), .rst(rst), .load_i(load_i), .ctl_i(ctl_in), .gs_i(gs_i),
    .ctl_o(ctl_q), .gs_o(gs_q), .restart_o(restart)
  );

  gs_ref_edge #(.SYNC(SYNC)) u_edge (
    .clk(clk), .rst(rst), .ref_int_i(ref_int_i), .ref_ext_i(ref_ext_i),
    .ext_sel_i(ctl_q.ext_sel), .rise_o(rise), .fall_o(fall)
  );

  gs_counter #(.W(W)) u_cnt (
    .clk(clk), .rst(rst), .rise_i(rise), .restart_i(restart),
    .blank_i(ctl_q.blank), .cnt_o(cnt)
  );

  gs_chan_out #(.CH(CH), .W(W)) u_out (
    .clk(clk), .rst(rst), .cnt_i(cnt), .gs_i(gs_q), .rise_i(rise),
    .fall_i(fall), .rise_mode_i(ctl_q.rise_mode), .blank_i(ctl_q.blank),
    .restart_i(restart), .pwm_o(pwm_o)
  );
endmodule

// File: tb/sim_gs_pwm_bank.sv
module sim_gs_pwm_bank;
  localparam int CLK_PERIOD = 10;
  localparam int CH = 12;
  localparam int W  = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ref_int = 1'b0, ref_ext = 1'b0, load = 1'b0;
  logic c_blank = 1'b0, c_rst_en = 1'b0, c_ext = 1'b0, c_rise = 1'b0;
  logic [CH*W-1:0] gs_flat = '0;
  logic [CH-1:0] pwm;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  logic [CH*W-1:0] gs_m = '0;
  int cnt_m = 0;
  logic [CH-1:0] exp_pwm = '0, pend = '0;
  bit blank_m = 1, ext_m = 0, rise_m = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gs_pwm_bank u0 (
    .clk(clk), .rst(rst), .ref_int_i(ref_int), .ref_ext_i(ref_ext),
    .load_i(load), .cfg_blank_i(c_blank), .cfg_restart_en_i(c_rst_en),
    .cfg_ext_sel_i(c_ext), .cfg_rise_i(c_rise), .gs_i(gs_flat), .pwm_o(pwm)
  );

  function automatic logic [CH-1:0] calc(int used);
    logic [CH-1:0] v = '0;
    for (int i = 0; i < CH; i++) v[i] = (used < int'(gs_m[i*W +: W]));
    return v;
  endfunction

  task automatic chk(string tag, logic [CH-1:0] act, logic [CH-1:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s: pwm_o=%h expected %h", tag, act, expv);
    end
  endtask

  task automatic set_all(int v);
    for (int i = 0; i < CH; i++) gs_flat[i*W +: W] = W'(v);
  endtask

  task automatic do_load(bit b, bit t, bit e, bit r, string tag);
    @(negedge clk);
    c_blank = b; c_rst_en = t; c_ext = e; c_rise = r; load = 1'b1;
    @(negedge clk);
    load = 1'b0;
    gs_m = gs_flat;
    if (t || (b != blank_m)) begin
      cnt_m = 0; exp_pwm = '0; pend = '0;
    end
    blank_m = b; ext_m = e; rise_m = r;
    repeat (2) @(negedge clk);
    chk(tag, pwm, exp_pwm);
  endtask

  task automatic pulse(bit on_ext, string tag);
    bit act;
    logic [CH-1:0] nv;
    act = (on_ext == ext_m) && !blank_m;
    @(negedge clk);
    if (on_ext) ref_ext = 1'b1; else ref_int = 1'b1;
    repeat (6) @(negedge clk);
    if (act) begin
      nv = calc(cnt_m);
      cnt_m = (cnt_m + 1) % 65536;
      pend = nv;
      if (rise_m) exp_pwm = nv;
    end
    chk(tag, pwm, exp_pwm);
    ref_ext = 1'b0; ref_int = 1'b0;
    repeat (6) @(negedge clk);
    if (act && !rise_m) exp_pwm = pend;
    chk(tag, pwm, exp_pwm);
  endtask

  task automatic t_reset();
    chk("R11", pwm, '0);
  endtask

  task automatic t_basic();
    for (int i = 0; i < CH; i++) gs_flat[i*W +: W] = W'(i);
    do_load(0, 1, 0, 1, "R5");
    for (int k = 0; k < 5; k++) pulse(0, "R2");
    do_load(0, 1, 0, 1, "R5");
    pulse(0, "R5");
  endtask

  task automatic t_ignore();
    set_all(16'hFFFF);
    c_blank = 1'b1; c_ext = 1'b1; c_rise = 1'b0;
    pulse(0, "R1");
    pulse(0, "R10");
    pulse(0, "R1");
    c_blank = 1'b0; c_ext = 1'b0; c_rise = 1'b1;
  endtask

  task automatic t_no_restart();
    set_all(4);
    do_load(0, 0, 0, 1, "R6");
    pulse(0, "R6");
  endtask

  task automatic t_clk_sel();
    set_all(2);
    do_load(0, 1, 0, 1, "R5");
    pulse(1, "R4");
    pulse(1, "R4");
    pulse(0, "R4");
    do_load(0, 1, 1, 1, "R4");
    pulse(0, "R4");
    for (int k = 0; k < 3; k++) pulse(1, "R4");
  endtask

  task automatic t_fall();
    set_all(1);
    do_load(0, 1, 0, 0, "R9");
    pulse(0, "R9");
    pulse(0, "R9");
    do_load(0, 1, 0, 1, "R9");
    pulse(0, "R9");
  endtask

  task automatic t_blank();
    set_all(3);
    do_load(0, 1, 0, 1, "R5");
    pulse(0, "R7");
    do_load(1, 0, 0, 1, "R7");
    for (int k = 0; k < 3; k++) pulse(0, "R8");
    do_load(0, 0, 0, 1, "R7");
    pulse(0, "R7");
  endtask

  task automatic t_wrap();
    set_all(0);
    gs_flat[0 +: W] = 16'hFFFF;
    gs_flat[W +: W] = 16'd1;
    do_load(0, 1, 0, 1, "R3");
    for (int k = 0; k < 65535; k++) begin
      @(negedge clk); ref_int = 1'b1;
      @(negedge clk); ref_int = 1'b0;
    end
    repeat (6) @(negedge clk);
    exp_pwm = calc(65534);
    pend = exp_pwm;
    cnt_m = 65535;
    chk("R3", pwm, exp_pwm);
    pulse(0, "R3");
    pulse(0, "R3");
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: pwm_o=%h expected completion", pwm);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_basic();
    t_ignore();
    t_no_restart();
    t_clk_sel();
    t_fall();
    t_blank();
    t_wrap();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule